// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for one system clock domain. A power-of-two prescaler divides a stream of count-enable ticks and feeds an 8-bit down counter. The counter starts from a software-written load value. Software must write a two-byte feed sequence before the counter runs out. When it runs out, the block raises a sticky timeout flag. In watchdog mode it also raises a one-cycle reset request. In timer mode the counter simply reloads and keeps counting.

A control byte sets the prescaler tap, the run control, the flag and the choice between two tick sources. Two configuration inputs can lock the timer. When both are high, the run and source-select bits read as 1, and software cannot turn the timer off or move it to the peripheral tick.

The register port uses address 0 for control, 1 for load and 2 for feed. Writes take effect on the clock edge. Reads are combinational.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, the control register reads 8'hE5, the load register reads 8'hFF, and both `timeout_flag` and `reset_req` are 0.
- R2: After a feed, the counter underflows on the selected tick numbered 2^(5+PRE)*(WDL+1)+1, and the flag is set on that tick. This gives 33 ticks for PRE=0, WDL=0 and 193 ticks for PRE=1, WDL=2.
- R3: With `wd_mode`=0, an underflow sets only the flag. The counter reloads and repeats the same period, and `reset_req` stays 0.
- R4: With `wd_mode`=1, an underflow raises `reset_req` for exactly one cycle, in the same cycle as the flag rises.
- R5: A feed is a write of 8'hA5 to address 2 followed directly by a write of 8'h5A to address 2. It reloads the prescaler and counter. Any other write between the two bytes cancels the feed.
- R6: Writing control bit 1 as 0 clears the flag, and writing it as 1 has no effect. A feed clears the flag only when `wd_mode`=1.
- R7: While control bit 2 (run) is 0, ticks are ignored and the count is held.
- R8: Control bit 0 picks the tick source: 1 selects `tick_osc` and 0 selects `tick_pclk`. The unselected input has no effect.
- R9: When `wd_mode` and `wd_lock` are both 1, the run and source bits read as 1, the timer counts `tick_osc`, and writes of 0 to those two bits are ignored.
- R10: A new load value takes effect only at the next feed or reload, never within a count already in progress.
- R11: If a feed completes on the same cycle as an underflowing tick, the feed wins: no flag and no reset request. If a software flag clear and an underflow fall on the same cycle, the flag is set.
- R12: The control layout is bits 7:5 for PRE, bits 4:3 reading 0, bit 2 for run, bit 1 for the flag and bit 0 for source select. Reading address 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_mode | input | 1 | 1 = watchdog mode (reset on timeout); also one lock input |
| wd_lock | input | 1 | Second lock input; with `wd_mode` forces run and source bits |
| tick_osc | input | 1 | Count enable from the watchdog oscillator domain |
| tick_pclk | input | 1 | Count enable from the peripheral clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 load, 2 feed |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| timeout_flag | output | 1 | Sticky underflow flag (control bit 1) |
| reset_req | output | 1 | One-cycle reset request on underflow in watchdog mode |

## Verification
Two pairs of events can fall on the same edge. The first pair is the closing 8'h5A feed byte and the tick that would underflow. The second pair is a control write that clears the flag and an underflowing tick. The bench provokes both by holding `tick_osc` high during the write cycle, with the earlier ticks counted so that this write lands exactly on tick 33. It then judges the result from the flag and `reset_req`. For the feed collision it also confirms that a full 33-tick period follows before the next underflow.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int PRE_W = 3,
  parameter int BASE_SHIFT = 5,
  parameter logic [7:0] KEY_FIRST = 8'hA5,
  parameter logic [7:0] KEY_SECOND = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wd_mode,
  input  logic       wd_lock,
  input  logic       tick_osc,
  input  logic       tick_pclk,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       timeout_flag,
  output logic       reset_req
);
  localparam int PSC_W = BASE_SHIFT + (1 << PRE_W);
  localparam logic [1:0] A_CTL = 2'd0, A_LOAD = 2'd1, A_FEED = 2'd2;

  logic [PRE_W-1:0] pre_r, pre_act;
  logic             run_r, src_r, flag_r, armed;
  logic [7:0]       load_r, cnt;
  logic [PSC_W-1:0] psc;

  function automatic logic [PSC_W-1:0] period(input logic [PRE_W-1:0] p);
    return PSC_W'(1) << (BASE_SHIFT + int'(p));
  endfunction

  wire locked    = wd_mode & wd_lock;
  wire run_eff   = run_r | locked;
  wire src_eff   = src_r | locked;
  wire tick      = run_eff & (src_eff ? tick_osc : tick_pclk);
  wire wr_ctl    = wr_en && wr_addr == A_CTL;
  wire wr_load   = wr_en && wr_addr == A_LOAD;
  wire feed_done = wr_en && wr_addr == A_FEED && wr_data == KEY_SECOND && armed;
  wire underflow = tick && psc == '0 && cnt == '0 && !feed_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_r     <= '1;
      pre_act   <= '1;
      run_r     <= 1'b1;
      src_r     <= 1'b1;
      flag_r    <= 1'b0;
      armed     <= 1'b0;
      load_r    <= 8'hFF;
      cnt       <= 8'hFF;
      psc       <= period('1);
      reset_req <= 1'b0;
    end else begin
      reset_req <= underflow & wd_mode;
      if (wr_en) armed <= (wr_addr == A_FEED && wr_data == KEY_FIRST);
      if (wr_ctl) begin
        pre_r <= wr_data[7:5];
        run_r <= wr_data[2];
        src_r <= wr_data[0];
      end
      if (wr_load) load_r <= wr_data;
      if (feed_done || underflow) begin
        pre_act <= pre_r;
        psc     <= period(pre_r);
        cnt     <= load_r;
      end else if (tick) begin
        if (psc != '0) psc <= psc - 1'b1;
        else begin
          cnt <= cnt - 1'b1;
          psc <= period(pre_act) - 1'b1;
        end
      end
      if (underflow) flag_r <= 1'b1;
      else if (feed_done && wd_mode) flag_r <= 1'b0;
      else if (wr_ctl && !wr_data[1]) flag_r <= 1'b0;
    end
  end

  assign timeout_flag = flag_r;

  always_comb begin
    case (rd_addr)
      A_CTL:   rd_data = {pre_r, 2'b00, run_eff, flag_r, src_eff};
      A_LOAD:  rd_data = load_r;
      default: rd_data = 8'h00;
    endcase
  end

  assert_req_only_wd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wd_mode));
  assert_req_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_req_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> timeout_flag);
  assert_feed_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_done && wd_mode) |=> !timeout_flag && !reset_req);
  assert_flag_fall_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_flag) |-> $past(wr_en));
  assert_flag_rise_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(run_eff && (tick_osc || tick_pclk)));
  assert_lock_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode && wd_lock && rd_addr == A_CTL) |-> (rd_data[2] && rd_data[0]));
endmodule

// File: tb/wdt_prescaled_test.sv
module wdt_prescaled_test;
  logic clk = 0, rst_n = 0;
  logic wd_mode = 0, wd_lock = 0, tick_osc = 0, tick_pclk = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic timeout_flag, reset_req;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; logic [1:0] a; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  wdt_prescaled uut (.clk(clk), .rst_n(rst_n), .wd_mode(wd_mode), .wd_lock(wd_lock),
    .tick_osc(tick_osc), .tick_pclk(tick_pclk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .timeout_flag(timeout_flag), .reset_req(reset_req));

  // monitor: pops expected items and compares against the ports
  initial forever begin
    @(negedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = q.pop_front();
      if (it.kind == 0) begin rd_addr = it.a; #1; got = rd_data; end
      else if (it.kind == 1) got = {7'd0, reset_req};
      else got = {7'd0, timeout_flag};
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, got, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    item_t it; it.kind = 0; it.a = a; it.exp = e; it.tag = t; q.push_back(it);
  endtask
  task automatic chk_rst(input logic e, input string t);
    item_t it; it.kind = 1; it.a = 0; it.exp = {7'd0, e}; it.tag = t; q.push_back(it);
  endtask
  task automatic chk_flag(input logic e, input string t);
    item_t it; it.kind = 2; it.a = 0; it.exp = {7'd0, e}; it.tag = t; q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk = 0);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; tick_osc = tk;
    @(negedge clk); wr_en = 0; tick_osc = 0;
  endtask
  task automatic feed(); wr(2, 8'hA5); wr(2, 8'h5A); endtask
  task automatic ticks(input int n, input bit pclk = 0);
    @(negedge clk);
    if (pclk) tick_pclk = 1; else tick_osc = 1;
    repeat (n) @(negedge clk);
    tick_osc = 0; tick_pclk = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_rd(0, 8'hE5, "R1 ctrl reset"); chk_rd(1, 8'hFF, "R1 load reset");
    chk_rst(0, "R1 req reset"); chk_flag(0, "R1 flag reset"); chk_rd(2, 8'h00, "R12 feed reads 0");

    wr(1, 8'h00); wr(0, 8'h05); feed();
    ticks(32); chk_rd(0, 8'h05, "R2 no flag at 32");
    ticks(1); chk_rd(0, 8'h07, "R2 flag at 33"); chk_rst(0, "R3 no req in timer mode");
    feed(); chk_flag(1, "R6 timer feed keeps flag");
    wr(0, 8'h07); chk_flag(1, "R6 write 1 no effect");
    wr(0, 8'h05); chk_flag(0, "R6 write 0 clears");
    ticks(32); chk_flag(0, "R3 first period 32");
    ticks(1); chk_flag(1, "R3 first period 33");
    wr(0, 8'h05);
    ticks(32); chk_flag(0, "R3 repeat period 32");
    ticks(1); chk_flag(1, "R3 repeat period 33"); chk_rst(0, "R3 no req on repeat");

    wr(0, 8'h05); ticks(32); wr(0, 8'h05, 1); chk_flag(1, "R11 set beats clear");

    wr(0, 8'h05); feed(); ticks(20); wr(1, 8'h05);
    ticks(13); chk_flag(1, "R10 old load in use");
    wr(0, 8'h05); ticks(192); chk_flag(0, "R10 new load 192");
    ticks(1); chk_flag(1, "R10 new load 193");
    wr(0, 8'h05); wr(1, 8'h00); feed();

    ticks(20); wr(2, 8'hA5); wr(1, 8'h00); wr(2, 8'h5A);
    ticks(13); chk_flag(1, "R5 aborted feed");
    wr(0, 8'h05); feed(); ticks(20); feed();
    ticks(32); chk_flag(0, "R5 feed reloads 32");
    ticks(1); chk_flag(1, "R5 feed reloads 33");

    wr(0, 8'h01); feed(); ticks(100); chk_flag(0, "R7 held while stopped");
    wr(0, 8'h05); ticks(32); chk_flag(0, "R7 resumed 32");
    ticks(1); chk_flag(1, "R7 resumed 33");

    wr(0, 8'h04); feed(); ticks(50); chk_rd(0, 8'h04, "R8 osc ignored");
    ticks(33, 1); chk_rd(0, 8'h06, "R8 pclk counts");

    wd_mode = 1;
    wr(1, 8'h02); wr(0, 8'h25); feed();
    ticks(192); chk_rd(0, 8'h25, "R2 wd 192"); chk_rst(0, "R4 no req early");
    ticks(1); chk_rst(1, "R4 req at 193"); chk_rd(0, 8'h27, "R2 wd flag 193");
    @(negedge clk); chk_rst(0, "R4 req one cycle");
    feed(); chk_flag(0, "R6 wd feed clears");

    wr(1, 8'h00); wr(0, 8'h05); feed(); ticks(31);
    wr(2, 8'hA5, 1); wr(2, 8'h5A, 1);
    chk_flag(0, "R11 feed beats uf"); chk_rst(0, "R11 no req");
    ticks(32); chk_flag(0, "R11 after feed 32");
    ticks(1); chk_flag(1, "R11 after feed 33"); chk_rst(1, "R4 req again");

    wd_lock = 1;
    wr(0, 8'h00); chk_rd(0, 8'h05, "R9 forced bits");
    ticks(40, 1); chk_flag(0, "R9 pclk ignored");
    ticks(32); chk_rst(0, "R9 osc 32");
    ticks(1); chk_rst(1, "R9 runs locked"); chk_rd(0, 8'h07, "R9 flag locked");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule